// File: doc/BRIEF.md
# Programmable PAL Vertical Sync Generator

This block produces the vertical timing signals of a 625-line interlaced PAL raster from a line-rate timebase. It counts lines from a frame-start marker and a start-of-line strobe, and from a small configuration set it works out where each field's vertical sync interval begins and ends and where the field identifier flips. It drives a VS level, a V flag for embedded timing codes that follows exactly the same timing, and a FIELD level.

Every edge is placed relative to a fixed nominal line for each field: line 622 for the odd field (FIELD = 0), whose interval runs across the 625-to-1 wrap, and line 310 for the even field (FIELD = 1). The sync start is a signed line offset from that nominal line. Each field can add one extra line of delay, or can take the rising edge half a line early at the mid-line strobe. End and field-toggle positions are unsigned line offsets from the same nominal lines. Configuration inputs are taken only at frame start, so a frame never runs on a mix of old and new settings.

Top module: `pal_vsync_gen`

## Requirements
- R1: The line number becomes 1 on a cycle with `frame_start` high. It then advances by one on every `line_start` and wraps from 625 back to 1. `frame_start` counts as a line start.
- R2: The sync begin line of a field is its nominal line (odd 622, even 310) plus the begin offset when `cfg_beg_early` is 0, or minus the offset when it is 1.
- R3: `cfg_dly_odd` adds one line to the odd field's begin line, and `cfg_dly_even` adds one line to the even field's begin line. Each affects only its own field.
- R4: When a field's half-line bit (`cfg_adv_odd` / `cfg_adv_even`) is 1, VS rises at the `half_line` strobe of the line before that field's begin line, and not at the begin line's start. When the bit is 0, VS rises at the start of the begin line.
- R5: VS falls at the start of line nominal + `cfg_end_ofs` of either field.
- R6: FIELD becomes 0 at the start of line 622 + `cfg_tog_ofs` and becomes 1 at the start of line 310 + `cfg_tog_ofs`.
- R7: `v_bit` equals VS on every cycle.
- R8: Configuration inputs are loaded only on a `frame_start` cycle, and they already govern the events of that cycle. Changes at any other time have no effect until the next frame start.
- R9: After reset the configuration holds begin 5, early 1, odd delay 0, even delay 1, both half-line bits 0, end 4, toggle 6. VS, `v_bit` and FIELD are 0, and `line_start` and `half_line` are ignored until the first `frame_start`.
- R10: Outputs change on the clock edge that samples the triggering strobe, one register stage. If a set and a clear fall on the same strobe, the clear wins.
- R11: All computed line positions wrap modulo 625 into the range 1..625.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| half_line | input | 1 | One-cycle strobe at mid-line |
| frame_start | input | 1 | One-cycle marker at the start of line 1 |
| cfg_beg_ofs | input | 5 | Sync begin offset in lines |
| cfg_beg_early | input | 1 | 1: begin earlier by the offset, 0: later |
| cfg_dly_odd | input | 1 | Extra one-line begin delay, odd field |
| cfg_dly_even | input | 1 | Extra one-line begin delay, even field |
| cfg_adv_odd | input | 1 | Half-line early begin, odd field |
| cfg_adv_even | input | 1 | Half-line early begin, even field |
| cfg_end_ofs | input | 5 | Sync end offset in lines |
| cfg_tog_ofs | input | 5 | Field toggle offset in lines |
| vs | output | 1 | Vertical sync level |
| v_bit | output | 1 | V flag for embedded timing codes |
| field | output | 1 | Field identifier, 0 odd, 1 even |

## Verification
The bench targets positions that wrap past line 625. It checks the odd-field begin line pulled back by five lines to 617, and the end and toggle lines pushed past the wrap to lines 1, 3 and 28. A design that compared without wrapping would never assert or release VS in those frames. It changes the configuration in the middle of each frame, which exposes a design that loads settings at any time other than frame start because its VS edges would move in the current frame. It also runs a frame where the begin and end lines coincide, which shows whether clear wins and whether the half-line early start still gives a half-line pulse. A last frame places the begin line after the end line, which catches an in-range check in place of set/clear edges.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  localparam int OFS_W = 5;

  // Index 0 is the odd field, index 1 the even field.
  typedef struct packed {
    logic [OFS_W-1:0] beg;
    logic             beg_early;
    logic [1:0]       dly;
    logic [1:0]       adv;
    logic [OFS_W-1:0] vend;
    logic [OFS_W-1:0] ftog;
  } vsg_cfg_t;

  localparam vsg_cfg_t CFG_DEFAULT = '{
    beg:       OFS_W'(5),
    beg_early: 1'b1,
    dly:       2'b10,
    adv:       2'b00,
    vend:      OFS_W'(4),
    ftog:      OFS_W'(6)
  };

  // Fold a line position one frame length at most into 1..n.
  function automatic int wrap_line(input int x, input int n);
    if (x > n)      return x - n;
    else if (x < 1) return x + n;
    else            return x;
  endfunction

endpackage

// File: rtl/vsg_cfg_hold.sv
module vsg_cfg_hold
  import vsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  vsg_cfg_t cfg_in,
  output vsg_cfg_t cfg_eff
);

  vsg_cfg_t held_q;
  vsg_cfg_t held_n;

  always_comb begin
    held_n  = load ? cfg_in : held_q;
    cfg_eff = load ? cfg_in : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= CFG_DEFAULT;
    else        held_q <= held_n;
  end

endmodule

// File: rtl/vsg_line_ctr.sv
module vsg_line_ctr #(
  parameter int NLINES = 625,
  parameter int LW     = $clog2(NLINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          frame_start,
  output logic [LW-1:0] line_q,
  output logic [LW-1:0] line_nxt,
  output logic          tick,
  output logic          running
);

  logic run_n;

  always_comb begin
    tick  = (line_start | frame_start) & (running | frame_start);
    run_n = running | frame_start;
    if (frame_start)
      line_nxt = LW'(1);
    else if (line_q == LW'(NLINES))
      line_nxt = LW'(1);
    else
      line_nxt = line_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= LW'(1);
      running <= 1'b0;
    end else begin
      if (tick) line_q <= line_nxt;
      running <= run_n;
    end
  end

endmodule

// File: rtl/vsg_edge_calc.sv
module vsg_edge_calc
  import vsg_pkg::*;
#(
  parameter int NLINES = 625,
  parameter int LW     = $clog2(NLINES + 1),
  parameter int NOM    = 622,
  parameter int FIDX   = 0
) (
  input  vsg_cfg_t      cfg,
  output logic [LW-1:0] beg_line,
  output logic [LW-1:0] pre_line,
  output logic [LW-1:0] end_line,
  output logic [LW-1:0] tog_line,
  output logic          adv
);

  int b_raw;
  int b_wrapped;

  always_comb begin
    b_raw     = NOM + (cfg.beg_early ? -int'(cfg.beg) : int'(cfg.beg))
                    + int'(cfg.dly[FIDX]);
    b_wrapped = wrap_line(b_raw, NLINES);
    beg_line  = LW'(b_wrapped);
    pre_line  = LW'(wrap_line(b_wrapped - 1, NLINES));
    end_line  = LW'(wrap_line(NOM + int'(cfg.vend), NLINES));
    tog_line  = LW'(wrap_line(NOM + int'(cfg.ftog), NLINES));
    adv       = cfg.adv[FIDX];
  end

endmodule

// File: rtl/pal_vsync_gen.sv
module pal_vsync_gen
  import vsg_pkg::*;
#(
  parameter int NLINES   = 625,
  parameter int NOM_ODD  = 622,
  parameter int NOM_EVEN = 310
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             half_line,
  input  logic             frame_start,
  input  logic [OFS_W-1:0] cfg_beg_ofs,
  input  logic             cfg_beg_early,
  input  logic             cfg_dly_odd,
  input  logic             cfg_dly_even,
  input  logic             cfg_adv_odd,
  input  logic             cfg_adv_even,
  input  logic [OFS_W-1:0] cfg_end_ofs,
  input  logic [OFS_W-1:0] cfg_tog_ofs,
  output logic             vs,
  output logic             v_bit,
  output logic             field
);

  localparam int LW = $clog2(NLINES + 1);
  localparam int NF = 2;

  vsg_cfg_t cfg_in;
  vsg_cfg_t cfg_eff;

  logic [LW-1:0] line_q;
  logic [LW-1:0] line_nxt;
  logic          tick;
  logic          running;

  logic [LW-1:0] beg_l [NF];
  logic [LW-1:0] pre_l [NF];
  logic [LW-1:0] end_l [NF];
  logic [LW-1:0] tog_l [NF];
  logic [NF-1:0] adv_f;

  logic vs_q, vb_q, fld_q;
  logic vs_n, fld_n;
  logic set_c, clr_c, mid_ok;

  always_comb begin
    cfg_in.beg       = cfg_beg_ofs;
    cfg_in.beg_early = cfg_beg_early;
    cfg_in.dly       = {cfg_dly_even, cfg_dly_odd};
    cfg_in.adv       = {cfg_adv_even, cfg_adv_odd};
    cfg_in.vend      = cfg_end_ofs;
    cfg_in.ftog      = cfg_tog_ofs;
  end

  vsg_cfg_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (frame_start),
    .cfg_in  (cfg_in),
    .cfg_eff (cfg_eff)
  );

  vsg_line_ctr #(.NLINES(NLINES), .LW(LW)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .frame_start (frame_start),
    .line_q      (line_q),
    .line_nxt    (line_nxt),
    .tick        (tick),
    .running     (running)
  );

  for (genvar g = 0; g < NF; g++) begin : g_fld
    vsg_edge_calc #(
      .NLINES (NLINES),
      .LW     (LW),
      .NOM    ((g == 0) ? NOM_ODD : NOM_EVEN),
      .FIDX   (g)
    ) u_calc (
      .cfg      (cfg_eff),
      .beg_line (beg_l[g]),
      .pre_line (pre_l[g]),
      .end_line (end_l[g]),
      .tog_line (tog_l[g]),
      .adv      (adv_f[g])
    );
  end

  // Next-state: set/clear events for VS, toggle events for FIELD.
  always_comb begin
    set_c  = 1'b0;
    clr_c  = 1'b0;
    mid_ok = half_line & ~line_start & ~frame_start & running;
    for (int k = 0; k < NF; k++) begin
      if (tick && (line_nxt == beg_l[k]) && !adv_f[k]) set_c = 1'b1;
      if (mid_ok && adv_f[k] && (line_q == pre_l[k]))  set_c = 1'b1;
      if (tick && (line_nxt == end_l[k]))               clr_c = 1'b1;
    end
    if (clr_c)      vs_n = 1'b0;
    else if (set_c) vs_n = 1'b1;
    else            vs_n = vs_q;

    fld_n = fld_q;
    if (tick) begin
      if (line_nxt == tog_l[0])      fld_n = 1'b0;
      else if (line_nxt == tog_l[1]) fld_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q  <= 1'b0;
      vb_q  <= 1'b0;
      fld_q <= 1'b0;
    end else begin
      vs_q  <= vs_n;
      vb_q  <= vs_n;
      fld_q <= fld_n;
    end
  end

  assign vs    = vs_q;
  assign v_bit = vb_q;
  assign field = fld_q;

endmodule

// File: rtl/pal_vsync_gen_chk.sv
module pal_vsync_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic line_start,
  input logic half_line,
  input logic frame_start,
  input logic vs,
  input logic v_bit,
  input logic field
);

  logic seen_fs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_fs <= 1'b0;
    else if (frame_start) seen_fs <= 1'b1;
  end

  // R9: nothing moves before the first frame marker
  a_r9_idle_until_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fs |-> (!vs && !v_bit && !field));

  // R10: VS only moves on the edge after a strobe
  a_r10_vs_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (vs != $past(vs)) |-> $past(line_start || half_line || frame_start));

  // R5: the sync interval always ends at a line start
  a_r5_vs_falls_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs) |-> $past(line_start || frame_start));

  // R6: FIELD flips only at a line start
  a_r6_field_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    (field != $past(field)) |-> $past(line_start || frame_start));

endmodule

bind pal_vsync_gen pal_vsync_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_start  (line_start),
  .half_line   (half_line),
  .frame_start (frame_start),
  .vs          (vs),
  .v_bit       (v_bit),
  .field       (field)
);

// File: tb/pal_vsync_gen_test.sv
module pal_vsync_gen_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ls = 1'b0, hl = 1'b0, fs = 1'b0;
  logic [4:0] c_beg = 5'd5, c_end = 5'd4, c_tog = 5'd6;
  logic c_early = 1'b1, c_do = 1'b0, c_de = 1'b1, c_ao = 1'b0, c_ae = 1'b0;
  logic vs, v_bit, field;

  pal_vsync_gen uut (
    .clk(clk), .rst_n(rst_n), .line_start(ls), .half_line(hl), .frame_start(fs),
    .cfg_beg_ofs(c_beg), .cfg_beg_early(c_early), .cfg_dly_odd(c_do),
    .cfg_dly_even(c_de), .cfg_adv_odd(c_ao), .cfg_adv_even(c_ae),
    .cfg_end_ofs(c_end), .cfg_tog_ofs(c_tog),
    .vs(vs), .v_bit(v_bit), .field(field)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string phase = "R9 idle";

  // Reference model state
  int m_line = 1;
  bit m_run = 0, m_vs = 0, m_fld = 0;
  int s_beg = 5, s_early = 1, s_do = 0, s_de = 1, s_ao = 0, s_ae = 0, s_end = 4, s_tog = 6;

  function automatic int wl(input int x);
    return ((x - 1) % 625 + 625) % 625 + 1;
  endfunction

  always @(posedge clk) begin
    int eb, ee, et, eo, edo, ede, eao, eae, b0, b1, nxt;
    bit st, cl;
    if (!rst_n) begin
      m_line = 1; m_run = 0; m_vs = 0; m_fld = 0;
      s_beg = 5; s_early = 1; s_do = 0; s_de = 1; s_ao = 0; s_ae = 0; s_end = 4; s_tog = 6;
    end else begin
      if (fs) begin
        s_beg = c_beg; s_early = c_early; s_do = c_do; s_de = c_de;
        s_ao = c_ao; s_ae = c_ae; s_end = c_end; s_tog = c_tog;
      end
      eb = s_beg; eo = s_early; edo = s_do; ede = s_de;
      eao = s_ao; eae = s_ae; ee = s_end; et = s_tog;
      b0 = wl(622 + (eo != 0 ? -eb : eb) + edo);
      b1 = wl(310 + (eo != 0 ? -eb : eb) + ede);
      st = 0; cl = 0;
      if ((ls || fs) && (m_run || fs)) begin
        nxt = fs ? 1 : wl(m_line + 1);
        if (nxt == b0 && eao == 0) st = 1;
        if (nxt == b1 && eae == 0) st = 1;
        if (nxt == wl(622 + ee) || nxt == wl(310 + ee)) cl = 1;
        if (nxt == wl(622 + et)) m_fld = 0;
        else if (nxt == wl(310 + et)) m_fld = 1;
        m_line = nxt;
        m_run = 1;
      end else if (hl && m_run) begin
        if (eao != 0 && wl(m_line + 1) == b0) st = 1;
        if (eae != 0 && wl(m_line + 1) == b1) st = 1;
      end
      if (cl) m_vs = 0;
      else if (st) m_vs = 1;
    end
  end

  task automatic check1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s line=%0d act=%b exp=%b", req, m_line, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check1({phase, " vs"}, vs, m_vs);
      check1("R7 v_bit follows vs", v_bit, m_vs);
      check1({phase, " field"}, field, m_fld);
    end
  end

  task automatic one_line(input bit first);
    @(negedge clk); ls = 1'b1; fs = first;
    @(negedge clk); ls = 1'b0; fs = 1'b0;
    repeat (3) @(negedge clk);
    hl = 1'b1;
    @(negedge clk); hl = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input int b, input bit e, input bit dod, input bit dev,
                         input bit aod, input bit aev, input int en, input int tg);
    c_beg = 5'(b); c_early = e; c_do = dod; c_de = dev;
    c_ao = aod; c_ae = aev; c_end = 5'(en); c_tog = 5'(tg);
  endtask

  // One frame; the next configuration is presented mid-frame (R8).
  task automatic frame(input string ph, input int b, input bit e, input bit dod, input bit dev,
                       input bit aod, input bit aev, input int en, input int tg);
    phase = ph;
    for (int ln = 1; ln <= 625; ln++) begin
      if (ln == 200) set_cfg(b, e, dod, dev, aod, aev, en, tg);
      one_line(ln == 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check1("R9 reset vs", vs, 1'b0);
    check1("R9 reset field", field, 1'b0);
    rst_n = 1'b1;
    phase = "R9 strobes before frame";
    for (int i = 0; i < 3; i++) one_line(1'b0);
    // defaults: begin 617/306, end 1/314, toggle 3/316 (R1 R2 R3 R5 R6 R11)
    frame("R1 R2 R3 R5 R6 R11 defaults", 1, 0, 0, 0, 0, 0, 4, 6);
    frame("R2 R8 later begin", 3, 1, 1, 0, 1, 0, 5, 2);
    frame("R3 R4 half-line odd", 3, 0, 0, 0, 0, 1, 3, 3);
    frame("R10 R4 begin equals end", 31, 0, 1, 0, 0, 0, 31, 31);
    frame("R11 wrap past 625", 5, 1, 0, 1, 0, 0, 4, 6);
    frame("R8 R1 back to defaults", 5, 1, 0, 1, 0, 0, 4, 6);
    for (int i = 0; i < 20; i++) one_line(1'b0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule